// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block is the transmit half of a synchronous serial port that runs as a clock slave. An external master drives the shift clock onto an input pin. The block presents one data bit per clock period on its serial output. It advances to the next bit on each falling edge of that clock, so the master can capture the bit on the rising edge. Words of 8 bits, or 9 bits when the ninth-bit mode is on, leave least-significant bit first.

Software-side logic writes words into a one-deep holding register that sits in front of the shift register. A word written while the shifter is idle goes straight into the shifter. A word written while another word is still leaving waits in the holding register, and the buffer-empty flag stays low while it waits. When the last bit of the current word has gone out, the waiting word moves into the shifter without a gap, and the buffer-empty flag rises. With the interrupt enable set, that flag also drives an interrupt or wake-up request. No part of the block needs an internally generated shift clock.

The shifter is a small state machine with three states. `ST_IDLE` holds the output at 0. `ST_DATA` sends the data bits. `ST_NINTH` sends the optional ninth bit. Its transitions are:
- IDLE→DATA on a load.
- DATA→DATA on a falling edge before the last data bit.
- DATA→NINTH on the falling edge after the last data bit in 9-bit mode.
- DATA→IDLE or NINTH→IDLE on the final falling edge when no word is waiting.
- DATA→DATA or NINTH→DATA on the final falling edge when a word is waiting (hand-off).
- Any state→IDLE when the block is not active (abort).

Top module: `sync_slave_tx`

## Requirements
- R1: After reset, `cfg_rdata` reads 8'h02, `buf_empty` is 1, `shift_empty` is 1, `sdo` is 0 and `irq` is 0.
- R2: The block shifts only while it is active. Active means the sync bit (bit 4) = 1, `port_en` = 1, the clock-select bit (bit 7) = 0, the transmit-enable bit (bit 5) = 1, `rx_cont_en` = 0 and `rx_single_en` = 0. A word written while the block is inactive waits in the holding register, so `buf_empty` = 0 and `shift_empty` = 1. It loads on the first cycle the block becomes active.
- R3: A word written while the shifter is idle and the block is active loads into the shifter on the same clock edge. `shift_empty` is 0 in the next cycle and `buf_empty` stays 1.
- R4: A word written while a word is shifting stays in the holding register, and `buf_empty` reads 0 until the hand-off.
- R5: On the falling external clock edge that ends the current word, a waiting word moves into the shifter. `buf_empty` returns to 1, `shift_empty` stays 0, and the waiting word is sent next with its first bit immediately on `sdo`.
- R6: `irq` is 1 exactly when `int_en` is 1 and `buf_empty` is 1.
- R7: Bits leave LSB first. Bit 0 appears on `sdo` when the word loads, and each falling edge of `ext_sck` advances by one bit. Between falling edges `sdo` does not change.
- R8: With the 9-bit mode bit (bit 6) set, a ninth bit follows bit 7. Its value is control bit 0, latched when the word loads. With bit 6 clear, control bit 0 is not sent.
- R9: Clearing transmit-enable or `port_en` abandons the word being shifted. Within two cycles `shift_empty` is 1 and `sdo` is 0, and the abandoned word is not resumed.
- R10: The control register holds bits 7..2 and 0 as written. Bit 1 is read-only and reads `shift_empty`.
- R11: `ext_sck` passes through a two-flop synchronizer. `sdo` changes in the third system-clock cycle after a falling edge of `ext_sck`, not earlier, so each phase of `ext_sck` must last at least 4 system-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| port_en | input | 1 | Serial port enable |
| rx_cont_en | input | 1 | Continuous receive enable (must be 0 to transmit) |
| rx_single_en | input | 1 | Single receive enable (must be 0 to transmit) |
| int_en | input | 1 | Transmit interrupt enable |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| wr_stb | input | 1 | Holding register write strobe |
| wr_data | input | DATA_W | Word to transmit |
| ext_sck | input | 1 | External shift clock from the master |
| sdo | output | 1 | Serial data output |
| buf_empty | output | 1 | Holding register empty flag |
| shift_empty | output | 1 | Shift register empty status |
| irq | output | 1 | Interrupt / wake request |

## Verification
Several corner cases are exercised, each with the failure it would expose:
- Two back-to-back writes. A design that let the second word overwrite the first, or raised `buf_empty` early, would lose a word or report free space that does not exist.
- The hand-off at the final falling edge. A gap there, or a late flag, shows up as a missing or shifted first bit of the second word.
- Writes made while a receive enable is set or clock-select is master. A design that shifted anyway, or dropped the word, fails the later readout.
- An abort in mid-word. A design that resumed the abandoned word, or left `sdo` high, is caught.
- The exact cycle after a falling edge at which `sdo` changes. This catches a synchronizer with the wrong depth.

// File: rtl/sst_pkg.sv
package sst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_NINTH = 2'd2
    } sst_state_e;

    localparam int CTRL_W      = 8;
    localparam int B_CLKSEL    = 7;
    localparam int B_NINE      = 6;
    localparam int B_TXEN      = 5;
    localparam int B_SYNC      = 4;
    localparam int B_STATUS    = 1;
    localparam int B_NINTH_BIT = 0;
endpackage

// File: rtl/sst_sck_sync.sv
module sst_sck_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    output logic fall_o
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], sck_i};
    end

    assign fall_o = pipe_q[STAGES] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
    import sst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              fall_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              load_nine_i,
    input  logic              load_ninth_i,
    output logic              ready_o,
    output logic              empty_o,
    output logic              sdo_o
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    sst_state_e        st_q, st_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic              nine_q, nine_d;
    logic              ninth_q, ninth_d;
    logic              word_end;

    assign word_end = fall_i & (((st_q == ST_DATA) & (idx_q == LAST_IDX) & ~nine_q)
                                | (st_q == ST_NINTH));
    assign ready_o  = (st_q == ST_IDLE) | word_end;

    always_comb begin
        st_d    = st_q;
        sh_d    = sh_q;
        idx_d   = idx_q;
        nine_d  = nine_q;
        ninth_d = ninth_q;
        if (!active_i) begin
            st_d = ST_IDLE;
        end else if (load_i) begin
            st_d    = ST_DATA;
            sh_d    = load_data_i;
            idx_d   = '0;
            nine_d  = load_nine_i;
            ninth_d = load_ninth_i;
        end else begin
            unique case (st_q)
                ST_IDLE: ;
                ST_DATA: begin
                    if (fall_i) begin
                        if (idx_q == LAST_IDX) begin
                            st_d = nine_q ? ST_NINTH : ST_IDLE;
                        end else begin
                            sh_d  = sh_q >> 1;
                            idx_d = idx_q + 1'b1;
                        end
                    end
                end
                ST_NINTH: if (fall_i) st_d = ST_IDLE;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            sh_q    <= '0;
            idx_q   <= '0;
            nine_q  <= 1'b0;
            ninth_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            sh_q    <= sh_d;
            idx_q   <= idx_d;
            nine_q  <= nine_d;
            ninth_q <= ninth_d;
        end
    end

    always_comb begin
        empty_o = 1'b0;
        sdo_o   = 1'b0;
        unique case (st_q)
            ST_IDLE:  empty_o = 1'b1;
            ST_DATA:  sdo_o   = sh_q[0];
            ST_NINTH: sdo_o   = ninth_q;
            default:  empty_o = 1'b1;
        endcase
    end

    // R9: inactive block is idle with a low output one cycle later
    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (empty_o && !sdo_o));

    // R7: data bit only moves after a detected falling edge
    assert_bit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA && $past(st_q) == ST_DATA && !$past(fall_i) && $past(active_i))
        |-> $stable(sdo_o));
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
    import sst_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              rx_cont_en,
    input  logic              rx_single_en,
    input  logic              int_en,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_sck,
    output logic              sdo,
    output logic              buf_empty,
    output logic              shift_empty,
    output logic              irq
);
    localparam logic [CTRL_W-1:0] STATUS_MASK = CTRL_W'(1) << B_STATUS;

    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] hold_q;
    logic              hold_full_q;
    logic              sck_fall, shf_ready, active;
    logic              take_hold, take_direct, load;
    logic [DATA_W-1:0] load_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (cfg_we) ctrl_q <= cfg_wdata & ~STATUS_MASK;
    end

    assign cfg_rdata = ctrl_q | (shift_empty ? STATUS_MASK : '0);

    assign active = ctrl_q[B_SYNC] & port_en & ~ctrl_q[B_CLKSEL] & ctrl_q[B_TXEN]
                  & ~rx_cont_en & ~rx_single_en;

    assign take_hold   = active & shf_ready & hold_full_q;
    assign take_direct = active & shf_ready & ~hold_full_q & wr_stb;
    assign load        = take_hold | take_direct;
    assign load_data   = hold_full_q ? hold_q : wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
        end else if (take_hold) begin
            hold_full_q <= wr_stb;
            if (wr_stb) hold_q <= wr_data;
        end else if (wr_stb && !take_direct) begin
            hold_full_q <= 1'b1;
            hold_q      <= wr_data;
        end
    end

    assign buf_empty = ~hold_full_q;
    assign irq       = int_en & buf_empty;

    sst_sck_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (ext_sck),
        .fall_o (sck_fall)
    );

    sst_shifter #(.DATA_W(DATA_W)) shf_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .active_i     (active),
        .fall_i       (sck_fall),
        .load_i       (load),
        .load_data_i  (load_data),
        .load_nine_i  (ctrl_q[B_NINE]),
        .load_ninth_i (ctrl_q[B_NINTH_BIT]),
        .ready_o      (shf_ready),
        .empty_o      (shift_empty),
        .sdo_o        (sdo)
    );

    // R3: write into an idle, active shifter starts shifting at once
    assert_direct_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && buf_empty && active && shift_empty) |=> (!shift_empty && buf_empty));

    // R4: write while shifter busy leaves the holding register full
    assert_hold_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !shf_ready) |=> !buf_empty);

    // R5: holding register only empties by feeding the shifter
    assert_handoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> !shift_empty);
endmodule

// File: tb/sync_slave_tx_tb_top.sv
module sync_slave_tx_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b1, rx_cont_en = 1'b0, rx_single_en = 1'b0, int_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0, cfg_rdata;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ext_sck = 1'b0;
    logic       sdo, buf_empty, shift_empty, irq;

    int total = 0, bad = 0;
    bit finished = 1'b0;
    logic [15:0] got;

    // {nine, ninth, data}
    localparam logic [9:0] VEC [0:5] = '{10'h0A5, 10'h03C, 10'h200, 10'h3FF, 10'h101, 10'h380};

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_slave_tx dut_i (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .rx_cont_en(rx_cont_en),
        .rx_single_en(rx_single_en), .int_en(int_en), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wr_stb(wr_stb),
        .wr_data(wr_data), .ext_sck(ext_sck), .sdo(sdo), .buf_empty(buf_empty),
        .shift_empty(shift_empty), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic put(input logic [7:0] d);
        @(negedge clk); wr_stb = 1'b1; wr_data = d;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic shift_bits(input int n, output logic [15:0] cap);
        cap = '0;
        for (int b = 0; b < n; b++) begin
            repeat (4) @(negedge clk);
            cap[b] = sdo;
            ext_sck = 1'b1;
            repeat (4) @(negedge clk);
            ext_sck = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cfg_rdata == 8'h02, "R1 cfg_rdata", 16'(cfg_rdata), 16'h02);
        check(buf_empty == 1'b1, "R1 buf_empty", 16'(buf_empty), 1);
        check(shift_empty == 1'b1, "R1 shift_empty", 16'(shift_empty), 1);
        check(sdo == 1'b0 && irq == 1'b0, "R1 sdo/irq", {14'b0, sdo, irq}, 0);

        // R7 / R8 / R3 vector table
        for (int v = 0; v < 6; v++) begin
            logic [9:0] e;
            logic [15:0] exp;
            int n;
            e = VEC[v];
            cfg(8'h30 | (e[9] ? 8'h40 : 8'h00) | (e[8] ? 8'h01 : 8'h00));
            put(e[7:0]);
            check(!shift_empty && buf_empty, "R3 direct load", {14'b0, shift_empty, buf_empty}, 16'h1);
            n   = e[9] ? 9 : 8;
            exp = e[9] ? {7'b0, e[8], e[7:0]} : {8'b0, e[7:0]};
            shift_bits(n, got);
            check(got == exp, "R7/R8 frame", got, exp);
            check(shift_empty, "R7 end of word", 16'(shift_empty), 1);
        end

        // R11 latency after falling edge, R10 status bit while busy
        cfg(8'h32);
        put(8'h01);
        check(cfg_rdata == 8'h30, "R10 readback busy", 16'(cfg_rdata), 16'h30);
        repeat (4) @(negedge clk);
        ext_sck = 1'b1;
        repeat (4) @(negedge clk);
        ext_sck = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(sdo == 1'b1, "R11 not yet advanced", 16'(sdo), 1);
        @(negedge clk);
        check(sdo == 1'b0, "R11 advanced", 16'(sdo), 0);
        shift_bits(7, got);
        check(got[6:0] == 7'h00 && shift_empty, "R11 rest of word", got, 0);

        // R4 / R5 / R6 double buffering
        int_en = 1'b1;
        put(8'h5A);
        put(8'hC3);
        check(!buf_empty, "R4 held word", 16'(buf_empty), 0);
        check(!irq, "R6 irq low", 16'(irq), 0);
        shift_bits(8, got);
        check(got == 16'h5A, "R7 first word", got, 16'h5A);
        check(buf_empty && !shift_empty, "R5 hand-off", {14'b0, buf_empty, shift_empty}, 16'h2);
        check(irq, "R6 irq high", 16'(irq), 1);
        shift_bits(8, got);
        check(got == 16'hC3, "R5 second word", got, 16'hC3);
        int_en = 1'b0;
        @(negedge clk);
        check(!irq && buf_empty, "R6 irq masked", 16'(irq), 0);

        // R2 blocked by receive enable, then by master clock select
        @(negedge clk); rx_cont_en = 1'b1;
        put(8'h81);
        check(shift_empty && !buf_empty, "R2 rx blocks", {14'b0, shift_empty, buf_empty}, 16'h2);
        rx_cont_en = 1'b0;
        @(negedge clk);
        check(!shift_empty && buf_empty, "R2 release loads", {14'b0, shift_empty, buf_empty}, 16'h1);
        shift_bits(8, got);
        check(got == 16'h81, "R2 released word", got, 16'h81);
        cfg(8'hB0);
        put(8'h42);
        check(shift_empty && !buf_empty, "R2 master blocks", {14'b0, shift_empty, buf_empty}, 16'h2);
        cfg(8'h30);
        @(negedge clk);
        check(!shift_empty, "R2 slave loads", 16'(shift_empty), 0);
        shift_bits(8, got);
        check(got == 16'h42, "R2 word after select", got, 16'h42);

        // R10 field storage
        cfg(8'hAC);
        check(cfg_rdata == 8'hAE, "R10 readback", 16'(cfg_rdata), 16'hAE);

        // R9 abort by transmit enable
        cfg(8'h30);
        put(8'hFF);
        shift_bits(3, got);
        check(sdo == 1'b1, "R9 mid word", 16'(sdo), 1);
        cfg(8'h10);
        @(negedge clk);
        check(shift_empty && !sdo, "R9 txen abort", {14'b0, shift_empty, sdo}, 16'h2);
        cfg(8'h30);
        @(negedge clk);
        check(shift_empty && buf_empty, "R9 no resume", {14'b0, shift_empty, buf_empty}, 16'h3);

        // R9 abort by port enable
        put(8'hFF);
        shift_bits(2, got);
        port_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(shift_empty && !sdo, "R9 port abort", {14'b0, shift_empty, sdo}, 16'h2);
        port_en = 1'b1;
        repeat (2) @(negedge clk);
        check(shift_empty, "R9 port no resume", 16'(shift_empty), 1);

        finish_run();
    end
endmodule